// File: doc/BRIEF.md
# Thermal Auto-Monitor Shutdown Controller

This block watches up to four temperature sensor channels without software involvement. A period timer driven by a prescaled tick starts a scan. The scan asks an external converter for one result per enabled channel, in ascending channel order, and holds each request until the converter answers. Each result is masked to the converter's meaningful width and stored. It is then compared against that channel's threshold code. By default the code falls as temperature rises, so a code at or below the threshold counts as over threshold.

Two separate consecutive-sample counters per channel debounce the response. One raises a pending interrupt bit. The other latches a shutdown condition that lasts until reset. Each channel's shutdown can be steered to an active-high reset output or to a general-purpose output whose active level is programmable. While any channel is over threshold, the timer uses a shorter high-temperature interval. A small register bus sets the enables, thresholds, debounce counts and both intervals.

Top module: `thermal_guard`

## Requirements
- R1: After reset, the control (0x04), interrupt-enable (0x08) and pending (0x0C) registers read 0. The normal period (0x68) reads 250, the high-temperature period (0x6C) reads 50, and both debounce registers (interrupt 0x60, shutdown 0x64) read 4. `irq` and `shut_rst` are 0 and `shut_gpio` is 1.
- R2: When the period expires with control bit 0 set, the channels whose control bit 4+ch is set are requested in ascending order, one at a time. `smp_req` and `smp_ch` hold steady until `smp_rdy`.
- R3: A channel whose control bit 4+ch is clear is never requested, and it never sets its pending bit.
- R4: A result is masked to its low DW bits and can be read at 0x20+4·ch. It counts as over threshold when the masked code is less than or equal to the threshold at 0x40+4·ch (the threshold value itself counts as over).
- R5: Pending bit ch in 0x0C sets when the interrupt debounce count of consecutive over-threshold samples is reached. Any sample that is not over threshold restarts the count from zero.
- R6: Writing 0x0C keeps only the pending bits that are written as 1. `irq` is the OR of the pending bits.
- R7: With interrupt-enable bit ch clear, channel ch never sets its pending bit.
- R8: The shutdown condition of a channel latches after the shutdown debounce count of consecutive over-threshold samples, counted independently of the interrupt count. It stays latched until reset.
- R9: A latched shutdown drives `shut_gpio` to its active level when interrupt-enable bit 4+ch is set, and drives `shut_rst` high when bit 8+ch is set. Control bit 8 set makes `shut_gpio` active high; clear makes it active low.
- R10: While any enabled channel's last sample was over threshold, the scan interval is the high-temperature period in ticks instead of the normal period.
- R11: Clearing control bit 0 stops all requests and clears the debounce counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Prescaled time-base pulse for the period timer |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` (combinational) |
| smp_req | output | 1 | Conversion request, held until `smp_rdy` |
| smp_ch | output | 2 | Channel being converted |
| smp_rdy | input | 1 | Converter result valid |
| smp_code | input | 12 | Converter result code |
| irq | output | 1 | High-temperature interrupt |
| shut_rst | output | 1 | Shutdown to the reset path, active high |
| shut_gpio | output | 1 | Shutdown to the general-purpose pin, programmable polarity |

## Verification
The bench builds the block with four channels and a 10-bit data mask (DW = 10). This lets a 12-bit converter code with high bits set show the masking, both in the stored result and in the comparison. The tick is held high and the bench programs periods of 10 and 3 ticks. The exact 7-cycle difference between a cold scan gap and a hot scan gap can then be measured directly. Short debounce counts of 1 to 4 let the interrupt and shutdown counters reach their limits, restart and saturate within a few scans.

// File: rtl/thermal_guard_pkg.sv
package thermal_guard_pkg;

    localparam int CODE_W = 12;
    localparam int MAX_CH = 4;
    localparam int CH_W   = 2;

    localparam logic [7:0] A_CTRL  = 8'h04;
    localparam logic [7:0] A_IEN   = 8'h08;
    localparam logic [7:0] A_PEND  = 8'h0C;
    localparam logic [7:0] A_DATA0 = 8'h20;
    localparam logic [7:0] A_THR0  = 8'h40;
    localparam logic [7:0] A_IDB   = 8'h60;
    localparam logic [7:0] A_SDB   = 8'h64;
    localparam logic [7:0] A_PNORM = 8'h68;
    localparam logic [7:0] A_PHOT  = 8'h6C;

    typedef enum logic {SCH_WAIT, SCH_SCAN} sched_st_e;

    typedef struct packed {
        logic              vld;
        logic [CH_W-1:0]   ch;
        logic [CODE_W-1:0] code;
    } sample_t;

    function automatic logic code_over(logic [CODE_W-1:0] code,
                                       logic [CODE_W-1:0] thr,
                                       logic falls);
        return falls ? (code <= thr) : (code >= thr);
    endfunction

    function automatic logic [7:0] ch_addr(logic [7:0] base, int ch);
        return base + 8'(ch * 4);
    endfunction

endpackage

// File: rtl/tg_regs.sv
module tg_regs
    import thermal_guard_pkg::*;
#(
    parameter int NCH = 4,
    parameter int PW  = 16,
    parameter int DBW = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        bus_wr,
    input  logic [7:0]                  bus_addr,
    input  logic [31:0]                 bus_wdata,
    output logic [31:0]                 bus_rdata,
    input  sample_t                     smp,
    input  logic [NCH-1:0]              irq_evt,
    output logic                        auto_en,
    output logic [NCH-1:0]              src_en,
    output logic                        pol_high,
    output logic [NCH-1:0]              irq_en,
    output logic [NCH-1:0]              gpio_rt,
    output logic [NCH-1:0]              rst_rt,
    output logic [NCH-1:0][CODE_W-1:0]  thr,
    output logic [DBW-1:0]              int_db,
    output logic [DBW-1:0]              shut_db,
    output logic [PW-1:0]               per_norm,
    output logic [PW-1:0]               per_hot,
    output logic [NCH-1:0]              pend
);

    localparam logic [PW-1:0]  PER_NORM_RST = PW'(250);
    localparam logic [PW-1:0]  PER_HOT_RST  = PW'(50);
    localparam logic [DBW-1:0] DB_RST       = DBW'(4);

    logic [NCH-1:0][CODE_W-1:0] data_q;
    logic [NCH-1:0]             pend_set;

    assign pend_set = irq_evt & irq_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            auto_en  <= 1'b0;
            src_en   <= '0;
            pol_high <= 1'b0;
            irq_en   <= '0;
            gpio_rt  <= '0;
            rst_rt   <= '0;
            thr      <= '0;
            data_q   <= '0;
            int_db   <= DB_RST;
            shut_db  <= DB_RST;
            per_norm <= PER_NORM_RST;
            per_hot  <= PER_HOT_RST;
            pend     <= '0;
        end else begin
            if (smp.vld) data_q[smp.ch] <= smp.code;
            if (bus_wr && bus_addr == A_PEND)
                pend <= (pend & bus_wdata[NCH-1:0]) | pend_set;
            else
                pend <= pend | pend_set;
            if (bus_wr) begin
                case (bus_addr)
                    A_CTRL: begin
                        auto_en  <= bus_wdata[0];
                        src_en   <= bus_wdata[4 +: NCH];
                        pol_high <= bus_wdata[8];
                    end
                    A_IEN: begin
                        irq_en  <= bus_wdata[0 +: NCH];
                        gpio_rt <= bus_wdata[4 +: NCH];
                        rst_rt  <= bus_wdata[8 +: NCH];
                    end
                    A_IDB:   int_db   <= bus_wdata[DBW-1:0];
                    A_SDB:   shut_db  <= bus_wdata[DBW-1:0];
                    A_PNORM: per_norm <= bus_wdata[PW-1:0];
                    A_PHOT:  per_hot  <= bus_wdata[PW-1:0];
                    default: ;
                endcase
                for (int c = 0; c < NCH; c++)
                    if (bus_addr == ch_addr(A_THR0, c))
                        thr[c] <= bus_wdata[CODE_W-1:0];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: begin
                bus_rdata[0]        = auto_en;
                bus_rdata[4 +: NCH] = src_en;
                bus_rdata[8]        = pol_high;
            end
            A_IEN: begin
                bus_rdata[0 +: NCH] = irq_en;
                bus_rdata[4 +: NCH] = gpio_rt;
                bus_rdata[8 +: NCH] = rst_rt;
            end
            A_PEND:  bus_rdata[NCH-1:0] = pend;
            A_IDB:   bus_rdata[DBW-1:0] = int_db;
            A_SDB:   bus_rdata[DBW-1:0] = shut_db;
            A_PNORM: bus_rdata[PW-1:0]  = per_norm;
            A_PHOT:  bus_rdata[PW-1:0]  = per_hot;
            default: ;
        endcase
        for (int c = 0; c < NCH; c++) begin
            if (bus_addr == ch_addr(A_DATA0, c)) bus_rdata[CODE_W-1:0] = data_q[c];
            if (bus_addr == ch_addr(A_THR0, c))  bus_rdata[CODE_W-1:0] = thr[c];
        end
    end

    // R7
    pend_gate_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> ((pend & ~$past(pend) & ~$past(irq_en)) == '0));

endmodule

// File: rtl/tg_sched.sv
module tg_sched
    import thermal_guard_pkg::*;
#(
    parameter int NCH = 4,
    parameter int PW  = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            auto_en,
    input  logic [NCH-1:0]  src_en,
    input  logic            hot,
    input  logic [PW-1:0]   per_norm,
    input  logic [PW-1:0]   per_hot,
    input  logic            smp_rdy,
    output logic            smp_req,
    output logic [CH_W-1:0] smp_ch,
    output logic            res_vld
);

    sched_st_e       state;
    logic [PW-1:0]   cnt;
    logic [CH_W-1:0] cur;
    logic            first_ok, nxt_ok;
    logic [CH_W-1:0] first_idx, nxt_idx;
    logic [PW-1:0]   per_sel, per_eff;
    logic            expire;

    always_comb begin
        first_ok  = 1'b0;
        first_idx = '0;
        nxt_ok    = 1'b0;
        nxt_idx   = '0;
        for (int c = NCH - 1; c >= 0; c--) begin
            if (src_en[c]) begin
                first_ok  = 1'b1;
                first_idx = CH_W'(c);
                if (c > int'(cur)) begin
                    nxt_ok  = 1'b1;
                    nxt_idx = CH_W'(c);
                end
            end
        end
    end

    assign per_sel = hot ? per_hot : per_norm;
    assign per_eff = (per_sel == '0) ? PW'(1) : per_sel;
    assign expire  = tick && (({1'b0, cnt} + (PW+1)'(1)) >= {1'b0, per_eff});

    assign smp_req = (state == SCH_SCAN) && auto_en;
    assign smp_ch  = cur;
    assign res_vld = smp_req && smp_rdy;

    always_ff @(posedge clk) begin
        if (rst || !auto_en) begin
            state <= SCH_WAIT;
            cnt   <= '0;
            cur   <= '0;
        end else begin
            case (state)
                SCH_WAIT: begin
                    if (expire) begin
                        cnt <= '0;
                        if (first_ok) begin
                            state <= SCH_SCAN;
                            cur   <= first_idx;
                        end
                    end else if (tick) begin
                        cnt <= cnt + PW'(1);
                    end
                end
                SCH_SCAN: begin
                    if (smp_rdy) begin
                        if (nxt_ok) cur <= nxt_idx;
                        else        state <= SCH_WAIT;
                    end
                end
                default: state <= SCH_WAIT;
            endcase
        end
    end

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_req && !smp_rdy) |=> (!auto_en || (smp_req && $stable(smp_ch))));

    // R2
    ascend_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_req && smp_rdy && nxt_ok) |=> (!auto_en || (smp_req && smp_ch > $past(smp_ch))));

endmodule

// File: rtl/tg_chan.sv
module tg_chan
    import thermal_guard_pkg::*;
#(
    parameter int DBW        = 8,
    parameter bit CODE_FALLS = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              res_vld,
    input  logic [CODE_W-1:0] code,
    input  logic [CODE_W-1:0] thr,
    input  logic [DBW-1:0]    int_db,
    input  logic [DBW-1:0]    shut_db,
    output logic              over_q,
    output logic              irq_evt,
    output logic              shut_q
);

    logic [DBW-1:0] icnt, scnt;
    logic [DBW-1:0] ieff, seff;
    logic           over;

    assign ieff    = (int_db == '0)  ? DBW'(1) : int_db;
    assign seff    = (shut_db == '0) ? DBW'(1) : shut_db;
    assign over    = code_over(code, thr, CODE_FALLS);
    assign irq_evt = active && res_vld && over && (icnt == ieff - DBW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            icnt   <= '0;
            scnt   <= '0;
            over_q <= 1'b0;
            shut_q <= 1'b0;
        end else if (!active) begin
            icnt   <= '0;
            scnt   <= '0;
            over_q <= 1'b0;
        end else if (res_vld) begin
            over_q <= over;
            if (over) begin
                if (icnt < ieff) icnt <= icnt + DBW'(1);
                if (scnt < seff) scnt <= scnt + DBW'(1);
                if (scnt == seff - DBW'(1)) shut_q <= 1'b1;
            end else begin
                icnt <= '0;
                scnt <= '0;
            end
        end
    end

    // R8
    shut_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        shut_q |=> shut_q);

    // R8
    shut_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(shut_q) |-> $past(res_vld));

    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        ((icnt != $past(icnt)) && (icnt != '0)) |-> $past(res_vld));

endmodule

// File: rtl/thermal_guard.sv
module thermal_guard
    import thermal_guard_pkg::*;
#(
    parameter int NCH        = 4,
    parameter int DW         = 12,
    parameter int PW         = 16,
    parameter int DBW        = 8,
    parameter bit CODE_FALLS = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        smp_req,
    output logic [1:0]  smp_ch,
    input  logic        smp_rdy,
    input  logic [11:0] smp_code,
    output logic        irq,
    output logic        shut_rst,
    output logic        shut_gpio
);

    localparam logic [CODE_W-1:0] DMASK = CODE_W'((1 << DW) - 1);

    logic                       auto_en, pol_high;
    logic [NCH-1:0]             src_en, irq_en, gpio_rt, rst_rt, pend;
    logic [NCH-1:0][CODE_W-1:0] thr;
    logic [DBW-1:0]             int_db, shut_db;
    logic [PW-1:0]              per_norm, per_hot;
    logic [NCH-1:0]             over_v, evt_v, shut_v;
    logic                       res_vld, gpio_act;
    sample_t                    smp;

    assign smp.vld  = res_vld;
    assign smp.ch   = smp_ch;
    assign smp.code = smp_code & DMASK;

    tg_regs #(.NCH(NCH), .PW(PW), .DBW(DBW)) u_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .smp(smp),
        .irq_evt(evt_v), .auto_en(auto_en), .src_en(src_en),
        .pol_high(pol_high), .irq_en(irq_en), .gpio_rt(gpio_rt),
        .rst_rt(rst_rt), .thr(thr), .int_db(int_db), .shut_db(shut_db),
        .per_norm(per_norm), .per_hot(per_hot), .pend(pend)
    );

    tg_sched #(.NCH(NCH), .PW(PW)) u_sched (
        .clk(clk), .rst(rst), .tick(tick), .auto_en(auto_en),
        .src_en(src_en), .hot(|over_v), .per_norm(per_norm),
        .per_hot(per_hot), .smp_rdy(smp_rdy), .smp_req(smp_req),
        .smp_ch(smp_ch), .res_vld(res_vld)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        tg_chan #(.DBW(DBW), .CODE_FALLS(CODE_FALLS)) u_chan (
            .clk(clk), .rst(rst),
            .active(auto_en && src_en[c]),
            .res_vld(res_vld && (smp_ch == CH_W'(c))),
            .code(smp.code), .thr(thr[c]),
            .int_db(int_db), .shut_db(shut_db),
            .over_q(over_v[c]), .irq_evt(evt_v[c]), .shut_q(shut_v[c])
        );
    end

    assign gpio_act  = |(shut_v & gpio_rt);
    assign shut_gpio = pol_high ? gpio_act : ~gpio_act;
    assign shut_rst  = |(shut_v & rst_rt);
    assign irq       = |pend;

endmodule

// File: tb/tb_thermal_guard.sv
`timescale 1ns/1ps
module tb_thermal_guard;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        smp_req;
    logic [1:0]  smp_ch;
    logic        smp_rdy = 1'b0;
    logic [11:0] smp_code = '0;
    logic        irq, shut_rst, shut_gpio;

    int checks = 0;
    int errors = 0;
    int ndone  = 0;
    int cyc    = 0;
    int log_n  = 0;
    int log_ch [64];
    logic [11:0] sens [4];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    thermal_guard #(.NCH(4), .DW(10)) dut (
        .clk(clk), .rst(rst), .tick(tick), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .smp_req(smp_req), .smp_ch(smp_ch), .smp_rdy(smp_rdy),
        .smp_code(smp_code), .irq(irq), .shut_rst(shut_rst),
        .shut_gpio(shut_gpio)
    );

    // converter model: answers two cycles after a request
    initial begin
        int lat;
        lat = 0;
        forever begin
            @(negedge clk);
            if (rst) begin
                smp_rdy = 1'b0; lat = 0;
            end else if (smp_rdy) begin
                smp_rdy = 1'b0; ndone++; lat = 0;
            end else if (smp_req) begin
                if (lat == 1) begin
                    smp_rdy  = 1'b1;
                    smp_code = sens[smp_ch];
                    if (log_n < 64) log_ch[log_n] = int'(smp_ch);
                    log_n++;
                end else lat++;
            end else lat = 0;
        end
    end

    task automatic check(input logic ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_samples(input int n);
        int tgt;
        tgt = ndone + n;
        while (ndone < tgt) @(negedge clk);
    endtask

    task automatic wait_rise(output int t);
        logic pr;
        pr = smp_req;
        forever begin
            @(negedge clk);
            if (smp_req && !pr) break;
            pr = smp_req;
        end
        t = cyc;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_periods();
        wr(8'h68, 32'd10);
        wr(8'h6C, 32'd3);
    endtask

    // code, threshold, expected stored data, expected pending (12 bits each)
    localparam logic [47:0] VEC [6] = '{
        {12'h150, 12'h150, 12'h150, 12'h001},
        {12'h151, 12'h150, 12'h151, 12'h000},
        {12'h14F, 12'h150, 12'h14F, 12'h001},
        {12'hC40, 12'h150, 12'h040, 12'h001},
        {12'h3FF, 12'h000, 12'h3FF, 12'h000},
        {12'h000, 12'h000, 12'h000, 12'h001}
    };

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r;
        int t1, t2, gap_c, gap_h, hits;
        for (int i = 0; i < 4; i++) sens[i] = 12'h3FF;
        do_reset();

        // R1 reset state
        rd(8'h04, r); check(r == 0, "R1 ctrl", r, 0);
        rd(8'h08, r); check(r == 0, "R1 ien", r, 0);
        rd(8'h0C, r); check(r == 0, "R1 pend", r, 0);
        rd(8'h68, r); check(r == 250, "R1 normal period", r, 250);
        rd(8'h6C, r); check(r == 50, "R1 hot period", r, 50);
        rd(8'h60, r); check(r == 4, "R1 int debounce", r, 4);
        rd(8'h64, r); check(r == 4, "R1 shut debounce", r, 4);
        check(irq == 0 && shut_rst == 0 && shut_gpio == 1, "R1 outputs",
              {irq, shut_rst, shut_gpio}, 3'b001);

        set_periods();
        // R4 R5 table walk
        for (int v = 0; v < 6; v++) begin
            wr(8'h04, 32'h0);
            wr(8'h0C, 32'h0);
            wr(8'h40, {20'h0, VEC[v][35:24]});
            sens[0] = VEC[v][47:36];
            wr(8'h08, 32'h1);
            wr(8'h60, 32'd2);
            wr(8'h64, 32'd100);
            wr(8'h04, 32'h11);
            wait_samples(3);
            rd(8'h0C, r);
            check(r[0] == VEC[v][0], "R4 over compare", r[0], VEC[v][0]);
            rd(8'h20, r);
            check(r[11:0] == VEC[v][23:12], "R4 masked data", r, VEC[v][23:12]);
            check(irq == VEC[v][0], "R6 irq follows pending", irq, VEC[v][0]);
        end

        // R6 write-back clear
        wr(8'h0C, 32'h0);
        wait_samples(1);
        rd(8'h0C, r); check(r == 0, "R6 pending cleared", r, 0);
        check(irq == 0, "R6 irq low after clear", irq, 0);

        // R5 restart on non-over sample
        wr(8'h04, 32'h0); wr(8'h0C, 32'h0);
        wr(8'h40, 32'h100); wr(8'h60, 32'd3); wr(8'h08, 32'h1);
        sens[0] = 12'h080;
        wr(8'h04, 32'h11);
        wait_samples(2); sens[0] = 12'h200;
        wait_samples(1); sens[0] = 12'h080;
        wait_samples(2);
        rd(8'h0C, r); check(r[0] == 0, "R5 count restarted", r[0], 0);
        wait_samples(1);
        rd(8'h0C, r); check(r[0] == 1, "R5 third consecutive", r[0], 1);

        // R7 interrupt disabled
        wr(8'h04, 32'h0); wr(8'h08, 32'h0); wr(8'h0C, 32'h0);
        wr(8'h60, 32'd1);
        wr(8'h04, 32'h11);
        wait_samples(4);
        rd(8'h0C, r); check(r == 0, "R7 no pending when disabled", r, 0);
        check(irq == 0, "R7 irq low", irq, 0);

        // R2 R3 ordering and skipped channel
        wr(8'h04, 32'h0); wr(8'h0C, 32'h0);
        for (int i = 0; i < 4; i++) sens[i] = 12'h3FF;
        sens[1] = 12'h000;
        wr(8'h40, 32'h0); wr(8'h48, 32'h0); wr(8'h4C, 32'h0);
        wr(8'h44, 32'h3FF);
        wr(8'h08, 32'h2);
        log_n = 0;
        wr(8'h04, 32'hD1);
        wait_samples(6);
        check(log_n >= 6, "R2 sample count", log_n, 6);
        for (int k = 0; k < 6; k++) begin
            int e;
            e = (k % 3 == 0) ? 0 : ((k % 3 == 1) ? 2 : 3);
            check(log_ch[k] == e, "R2 ascending order", log_ch[k], e);
        end
        rd(8'h0C, r); check(r[1] == 0, "R3 unenabled channel", r[1], 0);

        // R10 interval switch
        wr(8'h04, 32'h0); wr(8'h08, 32'h0);
        sens[0] = 12'h3FF; wr(8'h40, 32'h0);
        wr(8'h04, 32'h11);
        wait_rise(t1); wait_rise(t1); wait_rise(t2);
        gap_c = t2 - t1;
        sens[0] = 12'h000;
        wait_rise(t1); wait_rise(t1); wait_rise(t1); wait_rise(t2);
        gap_h = t2 - t1;
        check(gap_c - gap_h == 7, "R10 hot interval", gap_c - gap_h, 7);

        // R11 disable stops requests and clears counts
        wr(8'h04, 32'h0);
        hits = 0;
        repeat (40) begin
            @(negedge clk);
            if (smp_req) hits++;
        end
        check(hits == 0, "R11 no requests when off", hits, 0);
        wr(8'h0C, 32'h0); wr(8'h60, 32'd3); wr(8'h08, 32'h1);
        wr(8'h40, 32'h100); sens[0] = 12'h080;
        wr(8'h04, 32'h11);
        wait_samples(2);
        wr(8'h04, 32'h0);
        wr(8'h04, 32'h11);
        wait_samples(2);
        rd(8'h0C, r); check(r[0] == 0, "R11 counts cleared", r[0], 0);
        wait_samples(1);
        rd(8'h0C, r); check(r[0] == 1, "R11 count resumes", r[0], 1);

        // R8 R9 separate debounce, gpio route, sticky, polarity
        do_reset(); set_periods();
        wr(8'h40, 32'h100); sens[0] = 12'h080;
        wr(8'h60, 32'd2); wr(8'h64, 32'd4);
        wr(8'h08, 32'h11);
        wr(8'h04, 32'h11);
        wait_samples(2); @(negedge clk);
        check(irq == 1, "R8 irq at interrupt count", irq, 1);
        check(shut_gpio == 1, "R8 no shutdown yet", shut_gpio, 1);
        wait_samples(2); @(negedge clk);
        check(shut_gpio == 0, "R9 gpio active low", shut_gpio, 0);
        check(shut_rst == 0, "R9 reset route off", shut_rst, 0);
        sens[0] = 12'h300;
        wait_samples(2); @(negedge clk);
        check(shut_gpio == 0, "R8 shutdown sticky", shut_gpio, 0);
        wr(8'h04, 32'h111);
        check(shut_gpio == 1, "R9 gpio active high", shut_gpio, 1);

        // R9 reset route
        do_reset(); set_periods();
        check(shut_rst == 0, "R8 cleared by reset", shut_rst, 0);
        wr(8'h40, 32'h100); sens[0] = 12'h080;
        wr(8'h64, 32'd1); wr(8'h08, 32'h100);
        wr(8'h04, 32'h11);
        wait_samples(1); @(negedge clk);
        check(shut_rst == 1, "R9 reset route", shut_rst, 1);
        check(shut_gpio == 1, "R9 gpio idle", shut_gpio, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule